// File: doc/BRIEF.md
# Six-Source Interrupt Flag and Enable Controller

This block gathers single-cycle event pulses from six independent sources (alarm, periodic, update-ended, wake-up, kickstart and RAM-clear) and turns each into a sticky flag. The sources are split into two groups of three: a main group and an extended group. Each group has its own host-writable enable register and its own flag register. The block drives an active-low interrupt line. That line is low whenever at least one source has both its flag and its enable set.

The interrupt line is derived from the level of flag AND enable, not from the edge of an event. Software can therefore let an event sit unserviced and enable its source later. The line then asserts at once. A summary bit in both flag registers shows the same condition the line reports. The two groups clear their flags in different ways. Main flags clear when the main flag register is read. Extended flags clear only when a 0 is written to their bit.

The host port is a simple single-cycle register interface with separate read and write strobes, a 2-bit address and a registered read-data bus.

Top module: `intr_flag_ctrl`

## Requirements
- R1: After reset, all flags and enables are 0, `irq_n` is 1 and `rdata` is 0.
- R2: A 1 on `evt_pulse[i]` sets flag i at the next clock edge, whatever its enable. Bit order is: 0 alarm, 1 periodic, 2 update-ended, 3 wake-up, 4 kickstart, 5 RAM-clear.
- R3: `irq_n` goes low one clock after the edge at which some flag and its enable are both 1.
- R4: A flag whose enable is 0 never pulls `irq_n` low.
- R5: Writing a 1 to the enable of a source whose flag is already set drives `irq_n` low one clock after the write edge.
- R6: A read of address 2 returns main flags {alarm, periodic, update-ended} in bits [2:0] (bit 0 alarm) and clears those flags at the same edge. `irq_n` returns high one clock later if no other enabled flag remains.
- R7: A write to address 3 clears each extended flag whose `wdata` bit is 0 (bit 0 wake-up, bit 1 kickstart, bit 2 RAM-clear) and leaves the flags whose bit is 1. A read of address 3 returns these flags in bits [2:0] and does not clear them.
- R8: Bit 7 of a flag-register read is the OR over all six sources of (flag AND enable), sampled at the read edge.
- R9: When an event pulse and a clear for the same flag land on the same edge, the flag ends up set.
- R10: Address 0 holds the main enables and address 1 the extended enables, in bits [2:0] with the same bit order as the flags. These registers read back with the upper bits 0 and change only when written.
- R11: Writes to address 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 6 | One-cycle event pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address (0..3) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench first lets events arrive with the source disabled and checks that the line stays high while the flag is still recorded. It then enables the pending source and expects the line to fall one clock after the write. A design that sampled edges instead of levels would never assert in this case.

The bench reads the extended flag register twice to catch a design that clears on read in both groups. It writes a mixed mask to show that only the zero bits clear. It also lands an event on the same edge as a clearing read; a design that lets the clear win would lose that event. Every check on the line's timing is made one cycle apart from the next, so an output stage that was unregistered or registered twice would show up.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned GRP  = 3;
  localparam int unsigned NSRC = 2 * GRP;

  typedef enum logic [1:0] {
    A_EN_MAIN  = 2'd0,
    A_EN_EXT   = 2'd1,
    A_FLG_MAIN = 2'd2,
    A_FLG_EXT  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/intr_flag_bank.sv
module intr_flag_bank #(
  parameter int unsigned NSRC = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] flag_q
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    // set has priority over clear so no event is lost
    always_ff @(posedge clk) begin
      if (rst)         flag_q[i] <= 1'b0;
      else if (evt[i]) flag_q[i] <= 1'b1;
      else if (clr[i]) flag_q[i] <= 1'b0;
    end

    p_flag_set_r2: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> flag_q[i]);
    p_flag_clear_r6: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !evt[i]) |=> !flag_q[i]);
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && evt[i]) |=> flag_q[i]);
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (!clr[i] && !evt[i]) |=> flag_q[i] == $past(flag_q[i]));
  end
endmodule

// File: rtl/intr_enable_regs.sv
module intr_enable_regs #(
  parameter int unsigned GRP = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_main,
  input  logic             wr_ext,
  input  logic [GRP-1:0]   wval,
  output logic [2*GRP-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else begin
      if (wr_main) en_q[GRP-1:0]     <= wval;
      if (wr_ext)  en_q[2*GRP-1:GRP] <= wval;
    end
  end

  p_en_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!wr_main && !wr_ext) |=> $stable(en_q));
  p_en_load_r5: assert property (@(posedge clk) disable iff (rst)
    wr_ext |=> en_q[2*GRP-1:GRP] == $past(wval));
endmodule

// File: rtl/intr_irq_out.sv
module intr_irq_out #(
  parameter int unsigned NSRC = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] flag_q,
  input  logic [NSRC-1:0] en_q,
  output logic            summary,
  output logic            irq_n
);
  logic [NSRC-1:0] live;
  assign live    = flag_q & en_q;
  assign summary = |live;

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~summary;
  end

  p_irq_low_r3: assert property (@(posedge clk) disable iff (rst)
    (|(flag_q & en_q)) |=> !irq_n);
  p_irq_high_r4: assert property (@(posedge clk) disable iff (rst)
    ((flag_q & en_q) == '0) |=> irq_n);
endmodule

// File: rtl/intr_flag_ctrl.sv
module intr_flag_ctrl #(
  parameter int unsigned DW = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [intr_pkg::NSRC-1:0]   evt_pulse,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [1:0]                  addr,
  input  logic [DW-1:0]               wdata,
  output logic [DW-1:0]               rdata,
  output logic                        irq_n
);
  import intr_pkg::*;
  localparam int unsigned PADW = DW - GRP - 1;

  logic [NSRC-1:0] flag_q, en_q, clr;
  logic            summary;
  logic            wr_main_en, wr_ext_en, rd_main_flg, wr_ext_flg;
  logic [DW-1:0]   rd_mux;
  logic            unused_wdata;

  assign unused_wdata = ^wdata[DW-1:GRP];
  assign wr_main_en   = wr_en && (addr == A_EN_MAIN);
  assign wr_ext_en    = wr_en && (addr == A_EN_EXT);
  assign rd_main_flg  = rd_en && (addr == A_FLG_MAIN);
  assign wr_ext_flg   = wr_en && (addr == A_FLG_EXT);

  assign clr[GRP-1:0]     = {GRP{rd_main_flg}};
  assign clr[NSRC-1:GRP]  = wr_ext_flg ? ~wdata[GRP-1:0] : '0;

  intr_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk(clk), .rst(rst), .evt(evt_pulse), .clr(clr), .flag_q(flag_q));

  intr_enable_regs #(.GRP(GRP)) u_en (
    .clk(clk), .rst(rst), .wr_main(wr_main_en), .wr_ext(wr_ext_en),
    .wval(wdata[GRP-1:0]), .en_q(en_q));

  intr_irq_out #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst(rst), .flag_q(flag_q), .en_q(en_q),
    .summary(summary), .irq_n(irq_n));

  always_comb begin
    unique case (addr)
      A_EN_MAIN:  rd_mux = {1'b0, {PADW{1'b0}}, en_q[GRP-1:0]};
      A_EN_EXT:   rd_mux = {1'b0, {PADW{1'b0}}, en_q[NSRC-1:GRP]};
      A_FLG_MAIN: rd_mux = {summary, {PADW{1'b0}}, flag_q[GRP-1:0]};
      default:    rd_mux = {summary, {PADW{1'b0}}, flag_q[NSRC-1:GRP]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  p_summary_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[1]) |=> rdata[DW-1] == $past(|(flag_q & en_q)));
  p_en_pad_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !addr[1]) |=> rdata[DW-1:GRP] == '0);
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (irq_n && rdata == '0 && flag_q == '0 && en_q == '0));
endmodule

// File: tb/intr_flag_ctrl_bench.sv
module intr_flag_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] evt_pulse = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_n;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  intr_flag_ctrl u_intr_flag_ctrl (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n));

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic pulse(logic [5:0] m);
    @(negedge clk); evt_pulse = m;
    @(negedge clk); evt_pulse = '0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 irq_n", irq_n, 1);
    chk("R1 rdata", rdata, 0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 reg", v, 0);
    end
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    pulse(6'b000001);
    @(negedge clk);
    chk("R4 irq_n disabled", irq_n, 1);
    rd(2, v);
    chk("R2 flag set while disabled", v, 8'h01);
  endtask

  task automatic t_enabled();
    logic [7:0] v;
    wr(0, 8'h02);
    pulse(6'b000010);
    chk("R3 irq_n one-cycle latency", irq_n, 1);
    @(negedge clk);
    chk("R3 irq_n asserted", irq_n, 0);
    rd(2, v);
    chk("R8 summary with periodic", v, 8'h82);
    chk("R6 irq_n before release", irq_n, 0);
    @(negedge clk);
    chk("R6 irq_n released", irq_n, 1);
    rd(2, v);
    chk("R6 flags cleared by read", v, 8'h00);
  endtask

  task automatic t_late_enable();
    pulse(6'b010000);
    repeat (4) @(negedge clk);
    chk("R4 kick pending disabled", irq_n, 1);
    wr(1, 8'h02);
    chk("R5 latency after enable", irq_n, 1);
    @(negedge clk);
    chk("R5 irq on late enable", irq_n, 0);
  endtask

  task automatic t_ext_clear();
    logic [7:0] v;
    pulse(6'b101000);
    rd(3, v);
    chk("R7 ext read", v, 8'h87);
    rd(3, v);
    chk("R7 ext read not clearing", v, 8'h87);
    wr(3, 8'h05);
    rd(3, v);
    chk("R7 write-0 clears only kick", v, 8'h05);
    chk("R7 irq released", irq_n, 1);
    rd(1, v);
    chk("R10 ext enable readback", v, 8'h02);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    wr(0, 8'h01);
    @(negedge clk); rd_en = 1'b1; addr = 2; evt_pulse = 6'b000001;
    @(negedge clk); rd_en = 1'b0; evt_pulse = '0;
    rd(2, v);
    chk("R9 set wins over read clear", v, 8'h81);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(2, 8'hFF);
    rd(2, v);
    chk("R11 flag write ignored", v, 8'h00);
    wr(0, 8'hFF);
    rd(0, v);
    chk("R10 main enable pad", v, 8'h07);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_enabled();
    t_late_enable();
    t_ext_clear();
    t_collide();
    t_regs();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule